// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors kept in a word-addressed 32-bit memory and turns each one into a run of bytes on a byte-wide valid/ready stream. Each descriptor takes two consecutive memory words. The word at the lower address holds the byte count and the flag bits, and the one above it holds a byte address that points at the buffer. Software prepares one or more descriptors, then pulses a start input. The engine reads the descriptor at its current index, fetches the buffer one 32-bit word at a time and presents the bytes in address order. It then writes the flag word back, with the enable flag cleared and the outcome flags filled in, and moves to the next index.

Several descriptors in a row can form one frame: a "continue" flag tells the engine that the next descriptor carries more bytes of the same frame, and the end-of-frame marker is given only on the last byte of the first descriptor without that flag. The outcome of sending (underrun, retry limit, late collision) comes from outside the block as three status inputs. These inputs are sampled in the cycle in which a descriptor is written back. When the engine meets a descriptor whose enable flag is clear, it drops its transmit-enable state and stays idle until the start input is pulsed again. It then resumes at the index where it stopped.

Top module: `txr_engine`

## Requirements
- R1: After a synchronous reset the ring index is 0. The transmit-enable state (`txen_o`) and the interrupt flag (`irq_o`) are 0, and neither a memory request nor a stream byte is issued.
- R2: A `go_set` pulse sets `txen_o`. The engine then reads the flag word at word address `ring_base + 2*index` and the buffer address at `ring_base + 2*index + 1`.
- R3: The byte count is in flag-word bits [10:0] and the enable flag is bit 11 (0x800). When the flag word read has bit 11 clear, the engine streams no byte, writes nothing, keeps its index and clears `txen_o`. A `go_set` in that same cycle keeps `txen_o` set. When `txen_o` is 0, no memory request and no stream byte are issued.
- R4: The buffer address is a byte address. Byte k of a descriptor is lane `(addr+k) mod 4` of memory word `(addr+k) div 4`, with lane 0 in bits [7:0]. The bytes leave in increasing k, and a byte and its end marker hold while `tx_ready` is low.
- R5: Flag bit 17 (0x20000) means the next descriptor continues the frame. `tx_last` is high only on the final byte of a descriptor whose bit 17 is clear.
- R6: The engine writes back one word for each enabled descriptor, to the address of its flag word, one cycle after its final byte is accepted. The word is the flag word read, with bit 11 cleared and with bits 14, 15 and 16 replaced by `st_underrun`, `st_retry_limit` and `st_late_col`. All other bits are unchanged.
- R7: After a descriptor with flag bit 12 (0x1000) set, the next index is 0. Otherwise it is index+1, and after the index `RING_DEPTH-1` it is 0.
- R8: Writing back a descriptor with flag bit 13 (0x2000) set makes `irq_o` 1. It stays 1 until an `irq_clr` pulse, and a set in the same cycle wins over the clear.
- R9: A descriptor with byte count 0 produces no byte and is written back straight after its buffer address is read.
- R10: One start walks every consecutive enabled descriptor. A later start continues at the index after the last descriptor written back.

Every state and transition of the controller, by name:
- `S_IDLE` goes to `S_CTRL_REQ` while `txen_o` is set.
- `S_CTRL_REQ` goes to `S_CTRL_WAIT`.
- `S_CTRL_WAIT`, on the response, goes to `S_PTR_REQ` if the descriptor is enabled, and otherwise to `S_IDLE`.
- `S_PTR_REQ` goes to `S_PTR_WAIT`.
- `S_PTR_WAIT`, on the response, goes to `S_BUF_REQ`, or to `S_WRBACK` when the byte count is 0.
- `S_BUF_REQ` goes to `S_BUF_WAIT`.
- `S_BUF_WAIT`, on the response, goes to `S_SEND`.
- `S_SEND`, on an accepted byte, goes to `S_WRBACK` after the final byte, to `S_BUF_REQ` after lane 3, and otherwise stays in `S_SEND`.
- `S_WRBACK` goes to `S_CTRL_REQ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go_set | input | 1 | Pulse: set transmit-enable and start or continue the walk |
| irq_clr | input | 1 | Pulse: clear the interrupt flag |
| ring_base | input | AW | Word address of descriptor 0 |
| txen_o | output | 1 | Transmit-enable state |
| irq_o | output | 1 | Transmit interrupt flag |
| mem_req | output | 1 | Memory request, accepted in the cycle it is high |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Byte ends the frame |
| tx_ready | input | 1 | Stream sink accepts the byte |
| st_underrun | input | 1 | Outcome: underrun, written to flag bit 14 |
| st_retry_limit | input | 1 | Outcome: retry limit, written to flag bit 15 |
| st_late_col | input | 1 | Outcome: late collision, written to flag bit 16 |

## Verification
With a memory that answers one cycle after a read request, `txen_o` rises at the clock edge that samples `go_set`. The first flag-word read follows one cycle later. Each descriptor's write-back request is due exactly one cycle after the edge that accepts its final byte. The bench records the cycle number of every accepted byte and every write and compares the two for single-descriptor frames. All other results are compared only once `txen_o` has fallen, which happens two cycles after the read of the disabled descriptor that ends the walk. By then every byte, marker, write-back and interrupt change of the walk has settled, so those checks cannot sample early.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int LEN_W  = 11;
    localparam int B_EN   = 11;
    localparam int B_WRAP = 12;
    localparam int B_IRQ  = 13;
    localparam int B_UR   = 14;
    localparam int B_RL   = 15;
    localparam int B_LC   = 16;
    localparam int B_MORE = 17;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL_REQ,
        S_CTRL_WAIT,
        S_PTR_REQ,
        S_PTR_WAIT,
        S_BUF_REQ,
        S_BUF_WAIT,
        S_SEND,
        S_WRBACK
    } txr_state_e;

endpackage

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
    parameter int AW         = 16,
    parameter int RING_DEPTH = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          wrap,
    input  logic [AW-1:0] ring_base,
    output logic [AW-1:0] ctrl_addr,
    output logic [AW-1:0] ptr_addr
);
    localparam int IDXW = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;

    logic [IDXW-1:0] idx_q;
    logic [IDXW-1:0] idx_inc;

    generate
        if ((1 << IDXW) == RING_DEPTH) begin : g_pow2
            assign idx_inc = idx_q + 1'b1;
        end else begin : g_cmp
            assign idx_inc = (idx_q == IDXW'(RING_DEPTH - 1)) ? '0 : idx_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= wrap ? '0 : idx_inc;
        end
    end

    assign ctrl_addr = ring_base + AW'({idx_q, 1'b0});
    assign ptr_addr  = ctrl_addr + AW'(1);

endmodule

// File: rtl/txr_byte_pick.sv
module txr_byte_pick (
    input  logic [31:0] word,
    input  logic [1:0]  lane,
    output logic [7:0]  byte_o
);
    always_comb begin
        unique case (lane)
            2'd0: byte_o = word[7:0];
            2'd1: byte_o = word[15:8];
            2'd2: byte_o = word[23:16];
            default: byte_o = word[31:24];
        endcase
    end
endmodule

// File: rtl/txr_wb_word.sv
module txr_wb_word (
    input  logic [31:0] ctrl,
    input  logic        ur,
    input  logic        rl,
    input  logic        lc,
    output logic [31:0] wb
);
    always_comb begin
        wb                 = ctrl;
        wb[txr_pkg::B_EN]  = 1'b0;
        wb[txr_pkg::B_UR]  = ur;
        wb[txr_pkg::B_RL]  = rl;
        wb[txr_pkg::B_LC]  = lc;
    end
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
    parameter int AW         = 16,
    parameter int RING_DEPTH = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_set,
    input  logic          irq_clr,
    input  logic [AW-1:0] ring_base,
    output logic          txen_o,
    output logic          irq_o,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          st_underrun,
    input  logic          st_retry_limit,
    input  logic          st_late_col
);
    import txr_pkg::*;

    localparam int BAW = AW + 2;

    txr_state_e state_q, state_d;

    logic [31:0]      ctrl_q;
    logic [31:0]      word_q;
    logic [BAW-1:0]   baddr_q;
    logic [LEN_W-1:0] cnt_q;
    logic             txen_q;
    logic             irq_q;

    logic [AW-1:0]    ctrl_addr;
    logic [AW-1:0]    ptr_addr;
    logic [31:0]      wb_word;
    logic [7:0]       lane_byte;
    logic             advance;
    logic             byte_taken;
    logic             final_byte;

    assign advance    = (state_q == S_WRBACK);
    assign byte_taken = (state_q == S_SEND) && tx_ready;
    assign final_byte = (cnt_q == LEN_W'(1));

    txr_ring_index #(.AW(AW), .RING_DEPTH(RING_DEPTH)) u_index (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .wrap      (ctrl_q[B_WRAP]),
        .ring_base (ring_base),
        .ctrl_addr (ctrl_addr),
        .ptr_addr  (ptr_addr)
    );

    txr_byte_pick u_pick (
        .word   (word_q),
        .lane   (baddr_q[1:0]),
        .byte_o (lane_byte)
    );

    txr_wb_word u_wb (
        .ctrl (ctrl_q),
        .ur   (st_underrun),
        .rl   (st_retry_limit),
        .lc   (st_late_col),
        .wb   (wb_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (txen_q) state_d = S_CTRL_REQ;
            S_CTRL_REQ:  state_d = S_CTRL_WAIT;
            S_CTRL_WAIT: if (mem_rvalid) state_d = mem_rdata[B_EN] ? S_PTR_REQ : S_IDLE;
            S_PTR_REQ:   state_d = S_PTR_WAIT;
            S_PTR_WAIT:  if (mem_rvalid) state_d = (ctrl_q[LEN_W-1:0] == '0) ? S_WRBACK : S_BUF_REQ;
            S_BUF_REQ:   state_d = S_BUF_WAIT;
            S_BUF_WAIT:  if (mem_rvalid) state_d = S_SEND;
            S_SEND: begin
                if (tx_ready) begin
                    if (final_byte)                state_d = S_WRBACK;
                    else if (baddr_q[1:0] == 2'b11) state_d = S_BUF_REQ;
                    else                           state_d = S_SEND;
                end
            end
            S_WRBACK:    state_d = S_CTRL_REQ;
            default:     state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ctrl_addr;
        mem_wdata = wb_word;
        tx_valid  = 1'b0;
        unique case (state_q)
            S_CTRL_REQ: mem_req = 1'b1;
            S_PTR_REQ: begin
                mem_req  = 1'b1;
                mem_addr = ptr_addr;
            end
            S_BUF_REQ: begin
                mem_req  = 1'b1;
                mem_addr = baddr_q[BAW-1:2];
            end
            S_SEND:     tx_valid = 1'b1;
            S_WRBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
        tx_data = lane_byte;
        tx_last = (state_q == S_SEND) && final_byte && !ctrl_q[B_MORE];
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            word_q  <= '0;
            baddr_q <= '0;
            cnt_q   <= '0;
        end else begin
            if (state_q == S_CTRL_WAIT && mem_rvalid) ctrl_q <= mem_rdata;
            if (state_q == S_PTR_WAIT && mem_rvalid) begin
                baddr_q <= mem_rdata[BAW-1:0];
                cnt_q   <= ctrl_q[LEN_W-1:0];
            end
            if (state_q == S_BUF_WAIT && mem_rvalid) word_q <= mem_rdata;
            if (byte_taken) begin
                baddr_q <= baddr_q + 1'b1;
                cnt_q   <= cnt_q - 1'b1;
            end
        end
    end

    // transmit-enable and interrupt flags
    always_ff @(posedge clk) begin
        if (rst) begin
            txen_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (go_set)
                txen_q <= 1'b1;
            else if (state_q == S_CTRL_WAIT && mem_rvalid && !mem_rdata[B_EN])
                txen_q <= 1'b0;
            if (advance && ctrl_q[B_IRQ])
                irq_q <= 1'b1;
            else if (irq_clr)
                irq_q <= 1'b0;
        end
    end

    assign txen_o = txen_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/txr_engine_checks.sv
module txr_engine_checks (
    input logic       clk,
    input logic       rst,
    input logic       txen_o,
    input logic       irq_o,
    input logic       mem_req,
    input logic       mem_we,
    input logic       wb_en_bit,
    input logic       wb_irq_bit,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_last,
    input logic [7:0] tx_data
);
    // R4: a stalled byte and its marker hold
    a_r4_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R5: end marker only with a valid byte
    a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    // R6: written-back word never keeps the enable flag
    a_r6_wb_clears_enable: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !wb_en_bit);

    // R6: a write is always a request
    a_r6_write_needs_req: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R3: nothing moves while transmit-enable is off
    a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !txen_o |-> (!tx_valid && !mem_req));

    // R8: the flag rises only after writing back a descriptor that asked for it
    a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(mem_req && mem_we && wb_irq_bit));

endmodule

bind txr_engine txr_engine_checks u_chk (
    .clk        (clk),
    .rst        (rst),
    .txen_o     (txen_o),
    .irq_o      (irq_o),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .wb_en_bit  (mem_wdata[txr_pkg::B_EN]),
    .wb_irq_bit (mem_wdata[txr_pkg::B_IRQ]),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_last    (tx_last),
    .tx_data    (tx_data)
);

// File: tb/txr_engine_bench.sv
`timescale 1ns/1ps
module txr_engine_bench;
    localparam int AW    = 10;
    localparam int DEPTH = 4;
    localparam int BASE  = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, go_set = 1'b0, irq_clr = 1'b0, tx_ready = 1'b1;
    logic st_ur = 1'b0, st_rl = 1'b0, st_lc = 1'b0;
    logic [AW-1:0] ring_base = AW'(BASE);
    logic txen_o, irq_o, mem_req, mem_we, tx_valid, tx_last;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [7:0] tx_data;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    txr_engine #(.AW(AW), .RING_DEPTH(DEPTH)) u_txr_engine (
        .clk(clk), .rst(rst), .go_set(go_set), .irq_clr(irq_clr), .ring_base(ring_base),
        .txen_o(txen_o), .irq_o(irq_o), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_ready(tx_ready), .st_underrun(st_ur), .st_retry_limit(st_rl), .st_late_col(st_lc)
    );

    function automatic logic [7:0] pat(input int b);
        return 8'((b * 29 + 11) & 255);
    endfunction

    logic [31:0] mem [0:1023];
    logic bw_en = 1'b0, clr_log = 1'b0, stall_en = 1'b0, done = 1'b0;
    logic [AW-1:0] bw_addr = '0;
    logic [31:0] bw_data = '0;
    int cyc = 0, nget = 0, nreq = 0, nwr = 0, first_addr = 0, last_hs = 0, last_wr = 0;
    logic [7:0] got_b [0:63];
    logic       got_l [0:63];
    int nchk = 0, nerr = 0;

    // memory model (one-cycle read latency) and stream/request log
    always @(posedge clk) begin
        cyc        <= cyc + 1;
        mem_rvalid <= mem_req && !mem_we;
        mem_rdata  <= mem[mem_addr];
        if (rst) begin
            for (int w = 0; w < 1024; w++)
                mem[w] <= (w >= 256) ? {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)} : 32'h0;
        end else begin
            if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
            if (bw_en) mem[bw_addr] <= bw_data;
        end
        if (clr_log) begin
            nget <= 0; nreq <= 0; nwr <= 0;
        end else if (!rst) begin
            if (tx_valid && tx_ready && nget < 64) begin
                got_b[nget] <= tx_data;
                got_l[nget] <= tx_last;
                nget        <= nget + 1;
                last_hs     <= cyc;
            end
            if (mem_req && !mem_we) begin
                if (nreq == 0) first_addr <= int'(mem_addr);
                nreq <= nreq + 1;
            end
            if (mem_req && mem_we) begin
                nwr     <= nwr + 1;
                last_wr <= cyc;
            end
        end
    end

    always @(negedge clk) tx_ready <= stall_en ? ((cyc % 7) < 4) : 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bwrite(input int a, input logic [31:0] d);
        @(negedge clk);
        bw_en = 1'b1; bw_addr = AW'(a); bw_data = d;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic pulse_go();
        @(negedge clk) go_set = 1'b1;
        @(negedge clk) go_set = 1'b0;
    endtask

    task automatic log_clear();
        @(negedge clk) clr_log = 1'b1;
        @(negedge clk) clr_log = 1'b0;
    endtask

    task automatic wait_idle(output bit ok);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4000; i++) begin
            if (!txen_o) break;
            @(negedge clk);
        end
        ok = !txen_o;
        repeat (2) @(negedge clk);
    endtask

    int nd, midx = 0;
    int d_len [4], d_off [4];
    bit d_more [4], d_wrap [4], d_irq [4];
    bit [2:0] stat;

    task automatic run_batch(input string tag);
        int idx, start, total, fi, slot [4];
        logic [31:0] ctl [4];
        logic [7:0] eb [0:63];
        bit el [0:63];
        bit any_irq, ok;
        int ptr;
        logic [31:0] expw;
        start = midx; idx = midx; total = 0; any_irq = 0;
        for (int d = 0; d < nd; d++) begin
            slot[d] = idx;
            ptr = 1024 + 96 * idx + d_off[d];
            ctl[d] = 32'(d_len[d]) | 32'h800 | (32'(d_wrap[d]) << 12) | (32'(d_irq[d]) << 13)
                   | (32'(d_more[d]) << 17) | ((d_off[d] == 1) ? 32'h0010_0000 : 32'h0)
                   | ((d_off[d] == 3) ? 32'h0001_C000 : 32'h0);
            bwrite(BASE + 2*idx, ctl[d]);
            bwrite(BASE + 2*idx + 1, 32'(ptr));
            for (int k = 0; k < d_len[d]; k++) begin
                eb[total] = pat(ptr + k);
                el[total] = (k == d_len[d] - 1) && !d_more[d];
                total++;
            end
            any_irq |= d_irq[d];
            idx = (d_wrap[d] || idx == DEPTH - 1) ? 0 : idx + 1;
        end
        @(negedge clk);
        {st_ur, st_rl, st_lc} = stat;
        log_clear();
        pulse_go();
        wait_idle(ok);
        chk(ok, "R3", {tag, " walk stops at disabled descriptor"}, txen_o, 0);
        chk(first_addr == BASE + 2*start, "R2", {tag, " first read at ring_base+2*index (R7 R10)"},
            first_addr, BASE + 2*start);
        chk(nget == total, "R4", {tag, " byte count"}, nget, total);
        fi = -1;
        for (int i = 0; i < total && i < nget; i++)
            if (fi < 0 && got_b[i] !== eb[i]) fi = i;
        chk(fi < 0, "R4", {tag, " byte order and lanes"},
            (fi < 0) ? 0 : got_b[fi], (fi < 0) ? 0 : eb[fi]);
        fi = -1;
        for (int i = 0; i < total && i < nget; i++)
            if (fi < 0 && got_l[i] !== el[i]) fi = i;
        chk(fi < 0, "R5", {tag, " end-of-frame marker position"}, fi, -1);
        for (int d = 0; d < nd; d++) begin
            expw = (ctl[d] & ~32'h0001_C800) | (32'(stat[2]) << 14) | (32'(stat[1]) << 15)
                 | (32'(stat[0]) << 16);
            chk(mem[BASE + 2*slot[d]] == expw, "R6", {tag, " written-back word"},
                mem[BASE + 2*slot[d]], expw);
        end
        chk(nwr == nd, "R6", {tag, " one write-back per descriptor"}, nwr, nd);
        if (nd == 1 && total > 0)
            chk(last_wr == last_hs + 1, "R6", {tag, " write-back one cycle after last byte"},
                last_wr, last_hs + 1);
        chk(irq_o == any_irq, "R8", {tag, " interrupt flag"}, irq_o, any_irq);
        if (any_irq) begin
            @(negedge clk) irq_clr = 1'b1;
            @(negedge clk) irq_clr = 1'b0;
            chk(irq_o == 1'b0, "R8", {tag, " flag cleared by irq_clr"}, irq_o, 0);
        end
        midx = idx;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        bit ok;
        int it;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!txen_o && !irq_o, "R1", "flags clear after reset", {txen_o, irq_o}, 0);
        chk(!mem_req && !tx_valid, "R1", "no activity after reset", {mem_req, tx_valid}, 0);

        // sweep: byte offset x length, single descriptors, mixed flags and stalls
        it = 0;
        for (int off = 0; off < 4; off++) begin
            for (int len = 1; len <= 6; len++) begin
                nd = 1; d_len[0] = len; d_off[0] = off; d_more[0] = 0;
                d_wrap[0] = (it % 5 == 2); d_irq[0] = it[0]; stat = 3'(it % 8);
                stall_en = (it % 3 == 1);
                run_batch("sweep R4 R7");
                it++;
            end
        end

        // R9: zero-length descriptor
        nd = 1; d_len[0] = 0; d_off[0] = 0; d_more[0] = 0; d_wrap[0] = 0; d_irq[0] = 1;
        stat = 3'b101; stall_en = 0;
        run_batch("zero length R9");

        // R5 R9: gathered frame across three descriptors, middle one empty
        nd = 3; stall_en = 1; stat = 3'b010;
        d_len[0] = 5; d_off[0] = 2; d_more[0] = 1; d_wrap[0] = 0; d_irq[0] = 0;
        d_len[1] = 0; d_off[1] = 0; d_more[1] = 1; d_wrap[1] = 0; d_irq[1] = 0;
        d_len[2] = 4; d_off[2] = 1; d_more[2] = 0; d_wrap[2] = 0; d_irq[2] = 1;
        run_batch("gather R5");

        // R10: two separate frames in one walk
        nd = 2; stall_en = 0; stat = 3'b000;
        d_len[0] = 3; d_off[0] = 3; d_more[0] = 0; d_wrap[0] = 0; d_irq[0] = 0;
        d_len[1] = 2; d_off[1] = 0; d_more[1] = 0; d_wrap[1] = 0; d_irq[1] = 0;
        run_batch("two frames R10");

        // R3: start with the current descriptor disabled
        log_clear();
        pulse_go();
        wait_idle(ok);
        chk(ok, "R3", "disabled descriptor clears transmit-enable", txen_o, 0);
        chk(nget == 0 && nwr == 0, "R3", "no bytes or writes for disabled descriptor",
            nget + nwr, 0);
        chk(nreq == 1 && first_addr == BASE + 2*midx, "R3", "single read at unchanged index",
            first_addr, BASE + 2*midx);

        // R10: walk resumes at the same index afterwards
        nd = 1; d_len[0] = 7; d_off[0] = 1; d_more[0] = 0; d_wrap[0] = 1; d_irq[0] = 0;
        stat = 3'b111; stall_en = 1;
        run_batch("resume R10");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule